// File: doc/BRIEF.md
# Read-Only Instruction Cache Controller

This block controls a small first-level instruction cache whose lines are only ever read. The core presents instruction fetches by line address. A fetch that finds its line resident completes right away and the line's data comes back on a load-done channel. A fetch that misses installs nothing. It is taken from the core queue, and the controller sends a read-block request to one of several second-level banks. The bank is chosen by an address field just above the block offset, and the request goes out a fixed number of cycles after the miss. The request also carries a requestor ID and a cycle stamp.

Lines are placed only when fill data returns. If the fill's set still has a free way, or already holds the line, the data is written and load-done is reported. If both ways of the set are occupied, the least recently used way is invalidated in that cycle and the fill stays at the head of the response channel until the next cycle. A small table of outstanding miss addresses makes sure that no line has two misses in flight at the same time.

Top module: `icache_ctrl`

## Requirements
- R1: After reset every line is invalid and `done_valid`, `req_valid` and `err_out` are low.
- R2: A fetch whose line is resident is accepted (`fetch_ready` high) in its cycle. On the next cycle `done_valid` is high with that line's address and data.
- R3: A fetch whose line is absent is accepted without any load-done. Exactly `ISSUE_LAT` cycles after acceptance, `req_valid` rises for that line. The request holds its address until a cycle with `req_ready` high and drops on the next cycle.
- R4: `req_bank` equals the low `BANK_BITS` bits of the line address. `req_src` equals `SRC_ID`. `req_stamp` equals the number of clock edges since reset release, counted at the cycle the miss was accepted.
- R5: A data response (`rsp_is_data` = 1) whose set has a free way, or that already holds the line, is consumed in its cycle. On the next cycle `done_valid` shows its address and data, and later fetches of that line hit.
- R6: A data response whose set has both ways valid and does not hold the line is not consumed in its first cycle, and that cycle's victim is invalidated. The same response is consumed on the following cycle.
- R7: The victim is the way of the set used least recently, where both a fill and a hit count as a use.
- R8: A fetch to a line that has a miss outstanding is not accepted until that line's fill has been consumed. After that it hits.
- R9: While an issued request has not yet been accepted by the second level, a further missing fetch is not accepted.
- R10: When a response and a fetch are both valid in one cycle, the response is handled and `fetch_ready` is low.
- R11: A response with `rsp_is_data` = 0 is consumed and installs nothing. On the next cycle `err_out` pulses high for one cycle and `done_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch request present at queue head |
| fetch_addr | input | ADDR_W | Line address of the fetch |
| fetch_ready | output | 1 | Fetch dequeued this cycle |
| done_valid | output | 1 | Load-done to core |
| done_addr | output | ADDR_W | Line address of the completed load |
| done_data | output | DATA_W | Line data of the completed load |
| req_valid | output | 1 | Read-block request to second level |
| req_ready | input | 1 | Second level takes the request |
| req_addr | output | ADDR_W | Requested line address |
| req_bank | output | BANK_BITS | Destination bank |
| req_src | output | SRC_W | Requestor ID |
| req_stamp | output | STAMP_W | Cycle count when the miss was accepted |
| rsp_valid | input | 1 | Response present at queue head |
| rsp_is_data | input | 1 | 1 = system data response, 0 = illegal type |
| rsp_addr | input | ADDR_W | Line address of the response |
| rsp_data | input | DATA_W | Fill data |
| rsp_ready | output | 1 | Response dequeued this cycle |
| err_out | output | 1 | Illegal response seen on previous cycle |

## Verification
The bound checker watches four things on every cycle. It checks that the response channel has priority over fetches. It checks that an outstanding request stays stable until taken, and that a fill held back by an eviction is taken on the very next cycle. It checks that an illegal response is consumed and flagged, with no load-done. Other behaviours depend on the contents of the arrays and on history, so only the directed scenarios can show them. These are the choice of LRU victim, which line survives an eviction, the exact issue latency and cycle stamp, and the stall of a fetch behind a pending miss to the same line.

// File: rtl/icache_pkg.sv
package icache_pkg;
    typedef enum logic [2:0] {
        OP_IDLE,
        OP_BAD_RSP,
        OP_INSTALL,
        OP_EVICT,
        OP_HIT,
        OP_MISS,
        OP_STALL
    } icache_op_e;
endpackage

// File: rtl/icache_line_store.sv
module icache_line_store #(
    parameter int SETS   = 4,
    parameter int TAG_W  = 10,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAYS  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_set,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic [WAYS-1:0]   way_hit,
    output logic [WAYS-1:0]   way_used,
    output logic [DATA_W-1:0] hit_data,
    output logic              lru_way,
    input  logic              wr_en,
    input  logic              wr_way,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic              inv_way,
    input  logic              touch_en,
    input  logic              touch_way
) ;
    logic [DATA_W-1:0] way_data [WAYS];
    logic [SETS-1:0]   lru_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]   vld_q;
        logic [TAG_W-1:0]  tag_q [SETS];
        logic [DATA_W-1:0] dat_q [SETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= '0;
            end else if (wr_en && (wr_way == w[0])) begin
                vld_q[rd_set] <= 1'b1;
            end else if (inv_en && (inv_way == w[0])) begin
                vld_q[rd_set] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == w[0])) begin
                tag_q[rd_set] <= wr_tag;
                dat_q[rd_set] <= wr_data;
            end
        end

        assign way_used[w] = vld_q[rd_set];
        assign way_hit[w]  = vld_q[rd_set] && (tag_q[rd_set] == rd_tag);
        assign way_data[w] = dat_q[rd_set];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lru_q <= '0;
        end else if (touch_en) begin
            lru_q[rd_set] <= ~touch_way;
        end
    end

    assign lru_way  = lru_q[rd_set];
    assign hit_data = way_hit[1] ? way_data[1] : way_data[0];
endmodule

// File: rtl/icache_issue_delay.sv
module icache_issue_delay #(
    parameter int ADDR_W    = 12,
    parameter int BANK_BITS = 2,
    parameter int STAMP_W   = 16,
    parameter int LAT       = 80,
    localparam int CNT_W    = $clog2(LAT + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [ADDR_W-1:0]    ld_addr,
    input  logic [STAMP_W-1:0]   ld_stamp,
    output logic                 busy,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [ADDR_W-1:0]    out_addr,
    output logic [BANK_BITS-1:0] out_bank,
    output logic [STAMP_W-1:0]   out_stamp
);
    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [ADDR_W-1:0]  addr;
        logic [STAMP_W-1:0] stamp;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.busy && (slot_q.cnt != '0)) begin
            slot_d.cnt = slot_q.cnt - 1'b1;
        end
        if (out_valid && out_ready) begin
            slot_d.busy = 1'b0;
        end
        if (load) begin
            slot_d.busy  = 1'b1;
            slot_d.cnt   = CNT_W'(LAT);
            slot_d.addr  = ld_addr;
            slot_d.stamp = ld_stamp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign busy      = slot_q.busy;
    assign out_valid = slot_q.busy && (slot_q.cnt == '0);
    assign out_addr  = slot_q.addr;
    assign out_bank  = slot_q.addr[BANK_BITS-1:0];
    assign out_stamp = slot_q.stamp;
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int SETS      = 4,
    parameter int BANK_BITS = 2,
    parameter int ISSUE_LAT = 80,
    parameter int PEND      = 2,
    parameter int SRC_W     = 4,
    parameter logic [SRC_W-1:0] SRC_ID = 4'd5,
    parameter int STAMP_W   = 16,
    localparam int IDX_W    = $clog2(SETS),
    localparam int TAG_W    = ADDR_W - IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_valid,
    input  logic [ADDR_W-1:0]    fetch_addr,
    output logic                 fetch_ready,
    output logic                 done_valid,
    output logic [ADDR_W-1:0]    done_addr,
    output logic [DATA_W-1:0]    done_data,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [BANK_BITS-1:0] req_bank,
    output logic [SRC_W-1:0]     req_src,
    output logic [STAMP_W-1:0]   req_stamp,
    input  logic                 rsp_valid,
    input  logic                 rsp_is_data,
    input  logic [ADDR_W-1:0]    rsp_addr,
    input  logic [DATA_W-1:0]    rsp_data,
    output logic                 rsp_ready,
    output logic                 err_out
);
    typedef struct packed {
        logic                         done_v;
        logic [ADDR_W-1:0]            done_a;
        logic [DATA_W-1:0]            done_d;
        logic                         err;
        logic [PEND-1:0]              pv;
        logic [PEND-1:0][ADDR_W-1:0]  pa;
        logic [STAMP_W-1:0]           cyc;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [ADDR_W-1:0] lk_addr;
    logic [1:0]        way_hit, way_used;
    logic [DATA_W-1:0] hit_data;
    logic              lru_way, any_hit, set_full;
    logic              wr_en, wr_way, inv_en, touch_en, touch_way;
    logic              slot_busy, slot_load;
    logic              pend_match, pend_full, placed;
    icache_op_e        op;

    assign lk_addr  = rsp_valid ? rsp_addr : fetch_addr;
    assign any_hit  = |way_hit;
    assign set_full = &way_used;

    icache_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .rd_set(lk_addr[IDX_W-1:0]), .rd_tag(lk_addr[ADDR_W-1:IDX_W]),
        .way_hit(way_hit), .way_used(way_used), .hit_data(hit_data), .lru_way(lru_way),
        .wr_en(wr_en), .wr_way(wr_way), .wr_tag(rsp_addr[ADDR_W-1:IDX_W]), .wr_data(rsp_data),
        .inv_en(inv_en), .inv_way(lru_way),
        .touch_en(touch_en), .touch_way(touch_way)
    );

    icache_issue_delay #(.ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .STAMP_W(STAMP_W),
                         .LAT(ISSUE_LAT)) delay_i (
        .clk(clk), .rst_n(rst_n),
        .load(slot_load), .ld_addr(fetch_addr), .ld_stamp(st_q.cyc),
        .busy(slot_busy),
        .out_valid(req_valid), .out_ready(req_ready),
        .out_addr(req_addr), .out_bank(req_bank), .out_stamp(req_stamp)
    );

    always_comb begin
        pend_match = 1'b0;
        for (int i = 0; i < PEND; i++) begin
            if (st_q.pv[i] && (st_q.pa[i] == fetch_addr)) pend_match = 1'b1;
        end
        pend_full = &st_q.pv;

        if (rsp_valid) begin
            if (!rsp_is_data)             op = OP_BAD_RSP;
            else if (any_hit || !set_full) op = OP_INSTALL;
            else                           op = OP_EVICT;
        end else if (fetch_valid) begin
            if (any_hit)                                         op = OP_HIT;
            else if (!pend_match && !pend_full && !slot_busy)    op = OP_MISS;
            else                                                 op = OP_STALL;
        end else begin
            op = OP_IDLE;
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.done_v = 1'b0;
        st_d.err    = 1'b0;
        st_d.cyc    = st_q.cyc + 1'b1;
        rsp_ready   = 1'b0;
        fetch_ready = 1'b0;
        wr_en       = 1'b0;
        wr_way      = 1'b0;
        inv_en      = 1'b0;
        touch_en    = 1'b0;
        touch_way   = 1'b0;
        slot_load   = 1'b0;
        placed      = 1'b0;
        unique case (op)
            OP_BAD_RSP: begin
                rsp_ready = 1'b1;
                st_d.err  = 1'b1;
            end
            OP_INSTALL: begin
                rsp_ready   = 1'b1;
                wr_en       = 1'b1;
                wr_way      = any_hit ? way_hit[1] : way_used[0];
                touch_en    = 1'b1;
                touch_way   = wr_way;
                st_d.done_v = 1'b1;
                st_d.done_a = rsp_addr;
                st_d.done_d = rsp_data;
                for (int i = 0; i < PEND; i++) begin
                    if (st_q.pv[i] && (st_q.pa[i] == rsp_addr)) st_d.pv[i] = 1'b0;
                end
            end
            OP_EVICT: begin
                inv_en = 1'b1;
            end
            OP_HIT: begin
                fetch_ready = 1'b1;
                touch_en    = 1'b1;
                touch_way   = way_hit[1];
                st_d.done_v = 1'b1;
                st_d.done_a = fetch_addr;
                st_d.done_d = hit_data;
            end
            OP_MISS: begin
                fetch_ready = 1'b1;
                slot_load   = 1'b1;
                for (int i = 0; i < PEND; i++) begin
                    if (!placed && !st_q.pv[i]) begin
                        st_d.pv[i] = 1'b1;
                        st_d.pa[i] = fetch_addr;
                        placed     = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_valid = st_q.done_v;
    assign done_addr  = st_q.done_a;
    assign done_data  = st_q.done_d;
    assign err_out    = st_q.err;
    assign req_src    = SRC_ID;
endmodule

// File: rtl/icache_ctrl_chk.sv
module icache_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_ready,
    input logic              rsp_valid,
    input logic              rsp_is_data,
    input logic              rsp_ready,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              err_out,
    input logic              done_valid
);
    // R10
    rsp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !fetch_ready);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

    // R6
    held_fill_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_is_data && !rsp_ready) |=> (!rsp_valid || rsp_ready));

    // R11
    bad_rsp_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_is_data) |-> rsp_ready);

    // R11
    bad_rsp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_is_data) |=> (err_out && !done_valid));
endmodule

bind icache_ctrl icache_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .fetch_ready(fetch_ready),
    .rsp_valid(rsp_valid), .rsp_is_data(rsp_is_data), .rsp_ready(rsp_ready),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .err_out(err_out), .done_valid(done_valid)
);

// File: tb/icache_ctrl_tb_top.sv
`timescale 1ns/1ps
module icache_ctrl_tb_top;
    localparam int LAT = 80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [11:0] fetch_addr = '0;
    logic        fetch_ready;
    logic        done_valid;
    logic [11:0] done_addr;
    logic [31:0] done_data;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [11:0] req_addr;
    logic [1:0]  req_bank;
    logic [3:0]  req_src;
    logic [15:0] req_stamp;
    logic        rsp_valid = 1'b0;
    logic        rsp_is_data = 1'b0;
    logic [11:0] rsp_addr = '0;
    logic [31:0] rsp_data = '0;
    logic        rsp_ready;
    logic        err_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int acc_cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    icache_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
        .done_valid(done_valid), .done_addr(done_addr), .done_data(done_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bank(req_bank), .req_src(req_src), .req_stamp(req_stamp),
        .rsp_valid(rsp_valid), .rsp_is_data(rsp_is_data), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .rsp_ready(rsp_ready), .err_out(err_out)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        chk("R1 done_valid after reset", done_valid, 0);
        chk("R1 req_valid after reset", req_valid, 0);
        chk("R1 err_out after reset", err_out, 0);
    endtask

    task automatic t_miss(input logic [11:0] a);
        fetch_valid = 1'b1; fetch_addr = a;
        #1 chk("R3 missing fetch accepted", fetch_ready, 1);
        acc_cyc = cyc;
        @(posedge clk); @(negedge clk);
        fetch_valid = 1'b0;
        chk("R3 no load-done on miss", done_valid, 0);
    endtask

    task automatic t_take_req(input logic [11:0] a, input bit timed);
        int n = 0;
        while (!req_valid) begin
            @(negedge clk);
            n++;
        end
        if (timed) begin
            chk("R3 issue latency", n, LAT);
            chk("R4 request stamp", req_stamp, acc_cyc & 16'hffff);
        end
        chk("R3 request address", req_addr, a);
        chk("R4 bank field", req_bank, a[1:0]);
        chk("R4 requestor id", req_src, 5);
        repeat (3) begin
            @(negedge clk);
            chk("R3 request held", req_valid, 1);
            chk("R3 request address stable", req_addr, a);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R3 request dropped after accept", req_valid, 0);
    endtask

    task automatic t_fill(input logic [11:0] a, input logic [31:0] d);
        rsp_valid = 1'b1; rsp_is_data = 1'b1; rsp_addr = a; rsp_data = d;
        #1 chk("R5 fill consumed", rsp_ready, 1);
        @(posedge clk); @(negedge clk);
        rsp_valid = 1'b0;
        chk("R5 fill load-done", done_valid, 1);
        chk("R5 fill address", done_addr, a);
        chk("R5 fill data", done_data, d);
    endtask

    task automatic t_fill_full(input logic [11:0] a, input logic [31:0] d);
        rsp_valid = 1'b1; rsp_is_data = 1'b1; rsp_addr = a; rsp_data = d;
        #1 chk("R6 fill held when set full", rsp_ready, 0);
        @(posedge clk); @(negedge clk);
        chk("R6 no load-done while evicting", done_valid, 0);
        #1 chk("R6 fill consumed next cycle", rsp_ready, 1);
        @(posedge clk); @(negedge clk);
        rsp_valid = 1'b0;
        chk("R6 fill load-done", done_valid, 1);
        chk("R6 fill data", done_data, d);
    endtask

    task automatic t_hit(input logic [11:0] a, input logic [31:0] d, input string tag);
        fetch_valid = 1'b1; fetch_addr = a;
        #1 chk({tag, " hit accepted"}, fetch_ready, 1);
        @(posedge clk); @(negedge clk);
        fetch_valid = 1'b0;
        chk({tag, " hit load-done"}, done_valid, 1);
        chk({tag, " hit address"}, done_addr, a);
        chk({tag, " hit data"}, done_data, d);
    endtask

    task automatic t_busy_slot(input logic [11:0] pend_a, input logic [11:0] new_a);
        fetch_valid = 1'b1; fetch_addr = new_a;
        repeat (4) begin
            #1 chk("R9 miss stalls while request in flight", fetch_ready, 0);
            @(negedge clk);
        end
        t_take_req(pend_a, 1'b0);
        #1 chk("R9 miss accepted after request taken", fetch_ready, 1);
        acc_cyc = cyc;
        @(posedge clk); @(negedge clk);
        fetch_valid = 1'b0;
        t_take_req(new_a, 1'b1);
    endtask

    task automatic t_pending_and_priority(input logic [11:0] a, input logic [31:0] d);
        fetch_valid = 1'b1; fetch_addr = a;
        repeat (3) begin
            #1 chk("R8 fetch stalls behind pending miss", fetch_ready, 0);
            @(negedge clk);
        end
        rsp_valid = 1'b1; rsp_is_data = 1'b1; rsp_addr = a; rsp_data = d;
        #1 chk("R10 response taken first", rsp_ready, 1);
        chk("R10 fetch blocked by response", fetch_ready, 0);
        @(posedge clk); @(negedge clk);
        rsp_valid = 1'b0;
        chk("R5 fill data", done_data, d);
        #1 chk("R8 fetch accepted after fill", fetch_ready, 1);
        @(posedge clk); @(negedge clk);
        fetch_valid = 1'b0;
        chk("R8 fetch hits after fill", done_valid, 1);
        chk("R8 hit data", done_data, d);
    endtask

    task automatic t_bad_rsp(input logic [11:0] a);
        rsp_valid = 1'b1; rsp_is_data = 1'b0; rsp_addr = a; rsp_data = 32'hdead0000;
        #1 chk("R11 bad response consumed", rsp_ready, 1);
        @(posedge clk); @(negedge clk);
        rsp_valid = 1'b0;
        chk("R11 error flag", err_out, 1);
        chk("R11 no load-done", done_valid, 0);
        @(negedge clk);
        chk("R11 error flag one cycle", err_out, 0);
        t_miss(a);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R2 R3 R4 R5: set 0, bank 0
        t_miss(12'h010); t_take_req(12'h010, 1'b1);
        t_fill(12'h010, 32'haaaa0010);
        t_hit(12'h010, 32'haaaa0010, "R2");
        // R4: bank 3
        t_miss(12'h023); t_take_req(12'h023, 1'b1);
        t_fill(12'h023, 32'hbbbb0023);
        // second way of set 0, then touch A so C is least recent
        t_miss(12'h020); t_take_req(12'h020, 1'b1);
        t_fill(12'h020, 32'hcccc0020);
        t_hit(12'h010, 32'haaaa0010, "R7");
        // R6 R7: set 0 full, C evicted, A survives
        t_miss(12'h030); t_take_req(12'h030, 1'b1);
        t_fill_full(12'h030, 32'hdddd0030);
        t_miss(12'h020);
        t_hit(12'h010, 32'haaaa0010, "R7");
        t_hit(12'h030, 32'hdddd0030, "R6");
        t_busy_slot(12'h020, 12'h011);
        t_pending_and_priority(12'h011, 32'heeee0011);
        t_bad_rsp(12'h012);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule